// File: doc/BRIEF.md
# Engine Temperature Scaling and Smoothing Pipeline

This block serves one engine temperature channel. A raw sensor word arrives with a valid strobe and is held in an input register. Its low byte is read as degrees Celsius and turned into an approximate Fahrenheit value. The scaling uses a factor of 1.75, built as the sum of the value and two right-shifted copies of it. An offset of 32 is then added, so the path needs no multiplier. Results above the byte range clamp to the maximum.

The converted values feed a four-entry sliding window. Each accepted sample pushes out the oldest entry. The four entries are added at full precision, and the total is divided by four with a two-bit right shift. The smoothed temperature comes out with its own valid strobe. That strobe pulses once per accepted sample, but only after the window has been filled with real samples.

Top module: `tempavg_top`

## Requirements
- R1: A synchronous active-low reset drives `temp_vld` to 0 and `temp_out` to 0, and empties the window. Samples taken before a reset never contribute to a later output.
- R2: Each accepted sample is converted from its low 8 bits c as F = c + floor(c/2) + floor(c/4) + 32. So c = 0 gives 32, c = 100 gives 207, and c = 127 gives 253.
- R3: When F would exceed 255, the converted value is 255. Examples are c = 128 and c = 255.
- R4: Bits 11 down to 8 of `sample_raw` have no effect on any output.
- R5: `temp_out` is floor((F0 + F1 + F2 + F3) / 4) over the four newest converted samples. The sum is taken without dropping any bits first, so four samples of F = 35 give 35.
- R6: `temp_vld` stays 0 until four samples have been accepted since reset.
- R7: The window advances only on a cycle where `sample_vld` is 1. Idle cycles leave the window unchanged and produce no `temp_vld` pulse. Between pulses, `temp_out` holds its last value.
- R8: The result for a sample taken at rising edge n shows up after edge n+3, with `temp_vld` high for exactly that one cycle.
- R9: The window drops its oldest entry first. After converted values 32, 32, 32, 32 and then 207, the output is floor(303/4) = 75.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_raw | input | 12 | Raw sensor word; low byte is degrees Celsius |
| sample_vld | input | 1 | Marks `sample_raw` as a new sample this cycle |
| temp_out | output | 8 | Smoothed Fahrenheit temperature |
| temp_vld | output | 1 | One-cycle pulse when `temp_out` is new |

## Verification
The bench builds the block with its default parameters: a 12-bit raw word, 8-bit temperatures, four taps, and the offset at bit 5. At these values, a Celsius input of 128 or above pushes the unclamped result past the byte range, so the clamp can be reached with small vectors. The upper nibble of the raw word is live and can be shown to be ignored. Four taps is also small enough that filling the window, sliding it by one sample and spotting a per-sample rounding loss each take only a handful of samples.

// File: rtl/tempavg_pkg.sv
// Package: default geometry shared by the temperature pipeline.
// Assumes users override these only through module parameters.
package tempavg_pkg;
    localparam int RAW_W_DEF      = 12; // raw sensor word width
    localparam int TEMP_W_DEF     = 8;  // Celsius and Fahrenheit width
    localparam int TAPS_DEF       = 4;  // window depth, a power of two
    localparam int OFFSET_BIT_DEF = 5;  // offset 32 as a single set bit
endpackage

// File: rtl/tempavg_capture.sv
// Module: input register for the raw sensor word.
// Captures the word when the strobe is high and passes the strobe on
// one cycle later. Assumes a synchronous, active-low reset.
module tempavg_capture #(
    parameter int RAW_W = tempavg_pkg::RAW_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RAW_W-1:0] raw_in,
    input  logic             raw_vld,
    output logic [RAW_W-1:0] raw_q,
    output logic             raw_vld_q
);
    // Hold the latest accepted sample and delay its strobe one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q     <= '0;
            raw_vld_q <= 1'b0;
        end else begin
            raw_vld_q <= raw_vld;
            if (raw_vld) begin
                raw_q <= raw_in;
            end
        end
    end
endmodule

// File: rtl/tempavg_scale.sv
// Module: shift-add Celsius to Fahrenheit converter.
// Computes c + c/2 + c/4 + 2**OFFSET_BIT and clamps the result to the
// all-ones value. Assumes OFFSET_BIT < TEMP_W + 2, so the extra two
// bits always hold the unclamped sum.
module tempavg_scale #(
    parameter int TEMP_W     = tempavg_pkg::TEMP_W_DEF,
    parameter int OFFSET_BIT = tempavg_pkg::OFFSET_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] cel_in,
    input  logic              cel_vld,
    output logic [TEMP_W-1:0] fah_q,
    output logic              fah_vld_q
);
    localparam int EXT_W = TEMP_W + 2;
    localparam logic [EXT_W-1:0] OFFS = EXT_W'(1) << OFFSET_BIT;

    logic [EXT_W-1:0] wide_sum;
    logic [TEMP_W-1:0] clamped;

    // Add the three shifted copies and the offset in the widened domain.
    always_comb begin
        wide_sum = {2'b00, cel_in}
                 + {3'b000, cel_in[TEMP_W-1:1]}
                 + {4'b0000, cel_in[TEMP_W-1:2]}
                 + OFFS;
    end

    // Clamp to the top of the range whenever the extra bits are set.
    always_comb begin
        if (|wide_sum[EXT_W-1:TEMP_W]) begin
            clamped = '1;
        end else begin
            clamped = wide_sum[TEMP_W-1:0];
        end
    end

    // Register the converted value and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fah_q     <= '0;
            fah_vld_q <= 1'b0;
        end else begin
            fah_vld_q <= cel_vld;
            if (cel_vld) begin
                fah_q <= clamped;
            end
        end
    end

    // R2: scaling by 1.75 plus an offset never yields less than the input
    p_not_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cel_vld |=> (fah_q >= $past(cel_in)));

    // R3: the largest Celsius input always clamps to the top of the range
    p_clamp_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cel_vld && (&cel_in)) |=> (&fah_q));
endmodule

// File: rtl/tempavg_window.sv
// Module: sliding window of converted samples with a power-of-two mean.
// Shifts in one entry per valid input, adds every tap at full
// precision and divides by a right shift. Assumes TAPS is a power of two.
module tempavg_window #(
    parameter int TEMP_W = tempavg_pkg::TEMP_W_DEF,
    parameter int TAPS   = tempavg_pkg::TAPS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] smp_in,
    input  logic              smp_vld,
    output logic [TEMP_W-1:0] avg_q,
    output logic              avg_vld_q
);
    localparam int SHIFT = $clog2(TAPS);
    localparam int SUM_W = TEMP_W + SHIFT;
    localparam int CNT_W = $clog2(TAPS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(TAPS);

    logic [TEMP_W-1:0] tap_q [TAPS];
    logic [SUM_W-1:0]  psum  [TAPS+1];
    logic [CNT_W-1:0]  fill_q;
    logic              upd_q;

    // Shift the window on each valid sample, newest entry at tap 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) begin
                tap_q[i] <= '0;
            end
        end else if (smp_vld) begin
            tap_q[0] <= smp_in;
            for (int i = 1; i < TAPS; i++) begin
                tap_q[i] <= tap_q[i-1];
            end
        end
    end

    // Count accepted samples up to the window depth and flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= smp_vld;
            if (smp_vld && (fill_q != FULL)) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    // Add the taps one after another at the full sum width.
    assign psum[0] = '0;
    for (genvar g = 0; g < TAPS; g++) begin : g_acc
        assign psum[g+1] = psum[g] + {{SHIFT{1'b0}}, tap_q[g]};
    end

    // Publish the mean once per update after the window has filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg_q     <= '0;
            avg_vld_q <= 1'b0;
        end else begin
            avg_vld_q <= upd_q && (fill_q == FULL);
            if (upd_q && (fill_q == FULL)) begin
                avg_q <= psum[TAPS][SHIFT +: TEMP_W];
            end
        end
    end

    // R6: no result is published before the window is full
    p_no_early_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        avg_vld_q |-> (fill_q == FULL));

    // R7: every published result comes from an input accepted two edges earlier
    p_out_follows_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
        avg_vld_q |-> $past(smp_vld, 2));
endmodule

// File: rtl/tempavg_top.sv
// Module: top of the temperature pipeline for one channel.
// Chains the input register, the shift-add converter and the sliding
// mean. Only the low TEMP_W bits of the raw word are used. Assumes
// RAW_W > TEMP_W.
module tempavg_top #(
    parameter int RAW_W      = tempavg_pkg::RAW_W_DEF,
    parameter int TEMP_W     = tempavg_pkg::TEMP_W_DEF,
    parameter int TAPS       = tempavg_pkg::TAPS_DEF,
    parameter int OFFSET_BIT = tempavg_pkg::OFFSET_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAW_W-1:0]  sample_raw,
    input  logic              sample_vld,
    output logic [TEMP_W-1:0] temp_out,
    output logic              temp_vld
);
    logic [RAW_W-1:0]  raw_q;
    logic              raw_vld_q;
    logic [TEMP_W-1:0] fah_q;
    logic              fah_vld_q;
    logic              unused_hi;

    // The upper bits of the raw word are deliberately left unused.
    assign unused_hi = ^raw_q[RAW_W-1:TEMP_W];

    tempavg_capture #(.RAW_W(RAW_W)) i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_in    (sample_raw),
        .raw_vld   (sample_vld),
        .raw_q     (raw_q),
        .raw_vld_q (raw_vld_q)
    );

    tempavg_scale #(.TEMP_W(TEMP_W), .OFFSET_BIT(OFFSET_BIT)) i_scale (
        .clk       (clk),
        .rst_n     (rst_n),
        .cel_in    (raw_q[TEMP_W-1:0]),
        .cel_vld   (raw_vld_q),
        .fah_q     (fah_q),
        .fah_vld_q (fah_vld_q)
    );

    tempavg_window #(.TEMP_W(TEMP_W), .TAPS(TAPS)) i_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_in    (fah_q),
        .smp_vld   (fah_vld_q),
        .avg_q     (temp_out),
        .avg_vld_q (temp_vld)
    );

    // R8: a published result always matches a sample taken four edges earlier
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        temp_vld |-> $past(sample_vld, 4));
endmodule

// File: tb/test_tempavg_top.sv
`timescale 1ns/100ps
module test_tempavg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] sample_raw = '0;
    logic        sample_vld = 1'b0;
    logic [7:0]  temp_out;
    logic        temp_vld;

    int n_chk = 0;
    int n_err = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;
    string cur_req = "R1";

    // model state
    int  m_win [4];
    int  m_cnt = 0;
    bit  m_v [4];
    int  m_d [4];
    int  m_out = 0;

    always #2.5 clk = ~clk;

    tempavg_top i_tempavg_top (
        .clk(clk), .rst_n(rst_n), .sample_raw(sample_raw),
        .sample_vld(sample_vld), .temp_out(temp_out), .temp_vld(temp_vld)
    );

    function automatic int fconv(int raw);
        int c, f;
        c = raw & 255;
        f = c + c / 2 + c / 4 + 32;
        return (f > 255) ? 255 : f;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model, updated at each rising edge from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_win[i] = 0; m_v[i] = 0; m_d[i] = 0;
            end
            m_cnt = 0; m_out = 0;
        end else begin
            for (int i = 3; i > 0; i--) begin
                m_v[i] = m_v[i-1]; m_d[i] = m_d[i-1];
            end
            m_v[0] = 0;
            if (sample_vld) begin
                for (int i = 3; i > 0; i--) m_win[i] = m_win[i-1];
                m_win[0] = fconv(int'(sample_raw));
                if (m_cnt < 4) m_cnt++;
                m_v[0] = (m_cnt == 4);
                m_d[0] = (m_win[0] + m_win[1] + m_win[2] + m_win[3]) / 4;
            end
            if (m_v[3]) m_out = m_d[3];
        end
    end

    // Cycle-by-cycle comparison against the model (R7, R8 and the scenario tag).
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            chk(temp_vld == m_v[3], {cur_req, "/R8 strobe"}, temp_vld, m_v[3]);
            chk(int'(temp_out) == m_out, {cur_req, "/R7 value"}, temp_out, m_out);
        end
    end

    task automatic push(int v);
        sample_raw = 12'(v);
        sample_vld = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        sample_vld = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sample_vld = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push4_check(int v, int exp, string req);
        for (int i = 0; i < 4; i++) push(v);
        idle(3);
        chk(temp_vld == 1'b1, req, temp_vld, 1);
        chk(int'(temp_out) == exp, req, temp_out, exp);
        idle(1);
    endtask

    task automatic t_reset_state();
        cur_req = "R1";
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(temp_vld == 1'b0, "R1 reset strobe", temp_vld, 0);
        chk(temp_out == 8'd0, "R1 reset value", temp_out, 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
    endtask

    task automatic t_fill();
        cur_req = "R6";
        do_reset();
        for (int k = 0; k < 3; k++) begin
            push(0);
            idle(4);
            chk(temp_vld == 1'b0, "R6 no output before fourth sample", temp_vld, 0);
        end
        push(0);
        idle(3);
        chk(temp_vld == 1'b1, "R6 output after fourth sample", temp_vld, 1);
        chk(temp_out == 8'd32, "R2 zero Celsius gives 32", temp_out, 32);
        idle(1);
    endtask

    task automatic t_points();
        cur_req = "R2";
        push4_check(100, 207, "R2 100 Celsius gives 207");
        push4_check(127, 253, "R2 127 Celsius gives 253");
    endtask

    task automatic t_clamp();
        cur_req = "R3";
        push4_check(128, 255, "R3 128 Celsius clamps");
        push4_check(255, 255, "R3 255 Celsius clamps");
    endtask

    task automatic t_upper();
        cur_req = "R4";
        push4_check(12'hF64, 207, "R4 upper nibble ignored");
        push4_check(12'hA00, 32, "R4 upper nibble ignored at zero");
    endtask

    task automatic t_precision();
        cur_req = "R5";
        push4_check(2, 35, "R5 full-precision sum of 35s");
        push(1); push(1); push(1); push(2);
        idle(3);
        chk(temp_out == 8'd33, "R5 floor of 134/4", temp_out, 33);
        idle(1);
    endtask

    task automatic t_slide();
        cur_req = "R9";
        push4_check(0, 32, "R9 window of zeros");
        push(100);
        idle(3);
        chk(temp_out == 8'd75, "R9 oldest dropped first", temp_out, 75);
        push(100);
        idle(3);
        chk(temp_out == 8'd119, "R9 second slide", temp_out, 119);
        idle(1);
    endtask

    task automatic t_gaps();
        cur_req = "R7";
        push4_check(0, 32, "R7 baseline");
        push(100);
        idle(7);
        chk(temp_vld == 1'b0, "R7 no pulse on idle", temp_vld, 0);
        chk(temp_out == 8'd75, "R7 value held through idle", temp_out, 75);
        push(100);
        idle(2);
        push(100);
        idle(3);
        chk(temp_out == 8'd163, "R7 gaps do not shift window", temp_out, 163);
        idle(1);
    endtask

    task automatic t_latency();
        cur_req = "R8";
        idle(2);
        push(40);
        idle(2);
        chk(temp_vld == 1'b0, "R8 not yet at edge n+2", temp_vld, 0);
        idle(1);
        chk(temp_vld == 1'b1, "R8 strobe at edge n+3", temp_vld, 1);
        idle(1);
        chk(temp_vld == 1'b0, "R8 strobe lasts one cycle", temp_vld, 0);
    endtask

    task automatic t_reset_mid();
        cur_req = "R1";
        push4_check(255, 255, "R1 pre-reset fill");
        do_reset();
        chk(temp_out == 8'd0, "R1 reset clears value", temp_out, 0);
        push(100); push(100); push(100);
        idle(4);
        chk(temp_vld == 1'b0, "R1 window emptied by reset", temp_vld, 0);
        push(100);
        idle(3);
        chk(temp_out == 8'd207, "R1 old samples gone", temp_out, 207);
        idle(1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #20000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_fill();
        t_points();
        t_clamp();
        t_upper();
        t_precision();
        t_slide();
        t_gaps();
        t_latency();
        t_reset_mid();
        idle(4);
        finish_run();
    end
endmodule